// File: doc/BRIEF.md
# Legacy Processor Presence Bitmap Port

This block keeps a presence map with one bit per processor. The bit position is the processor's interrupt-controller ID. Host software reads the map one byte at a time through a 32-byte window and compares successive reads to find processors that were newly added. The platform reports a hot-add through a one-cycle input that carries the ID. The block sets the matching bit and latches a general-purpose event status. That status, gated by its enable, drives a system interrupt request. The platform never clears a presence bit, because removal is not supported in this view.

Software can write to the window, but a write changes only one thing. A write of zero to the first 32-bit word moves the port from state `ST_LEGACY` to state `ST_MODERN` through the transition `SWITCH`. From then on the newer hotplug interface takes over. The legacy window reads as zeros and ignores further writes and hot-add reports until reset. `ST_MODERN` has a single transition, `STAY`, back to itself. Reset is the only way to return to `ST_LEGACY`.

Top module: `cpu_pres_legacy_port`

## Requirements
- R1: After reset the map holds the power-up presence vector parameter, the event status is 0, legacy_mode is 1, rd_data is 0 and rd_valid is 0.
- R2: A read (rd_en high with byte address A) returns map bits 8A+7 down to 8A on rd_data in the next cycle, with bit k of the map equal to processor ID k. rd_valid is high in exactly the cycles that follow a cycle with rd_en high.
- R3: Map positions at or above the processor count, up to the last bit of the 32-byte window, always read as 0.
- R4: In legacy mode, a hot-add with an ID below the processor count sets that map bit and sets the event status, both visible in the next cycle.
- R5: A hot-add with an ID at or above the processor count changes neither the map nor the event status.
- R6: Presence bits are never cleared in legacy mode. Writes other than value 0 to byte addresses 0 to 3, and all writes to byte addresses 4 to 31, leave both the map and the mode unchanged.
- R7: A write of value 0 to any byte address 0 to 3 while in legacy mode drives legacy_mode to 0 in the next cycle.
- R8: Once legacy_mode is 0, it stays 0 until reset. Reads that complete in this state return 0, and hot-add reports no longer set the event status.
- R9: The event status stays set until a clear pulse, and the clear takes effect in the next cycle. A hot-add accepted in the same cycle as a clear wins, so the status stays 1. sci equals the event status ANDed with the enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_add_valid | input | 1 | One-cycle hot-add report |
| hot_add_id | input | 8 | Interrupt-controller ID of the added processor |
| win_addr | input | 5 | Byte address in the window |
| rd_en | input | 1 | Byte read request |
| wr_en | input | 1 | Word write request |
| wr_data | input | 32 | Write value |
| gpe_en | input | 1 | Event enable |
| gpe_clr | input | 1 | Write-one-to-clear pulse for the event status |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | rd_data holds a fresh read |
| gpe_sts | output | 1 | Latched hot-add event status |
| sci | output | 1 | System interrupt request |
| legacy_mode | output | 1 | 1 in ST_LEGACY, 0 in ST_MODERN |

## Verification
Several rules are checked on every cycle:
- the mode only ever leaves legacy after a zero write to the first word, and never returns;
- the event status rises only after an accepted hot-add, holds until cleared and drops after a clear with no hot-add;
- sci is never high without both status and enable;
- rd_valid follows rd_en one cycle later;
- reads completing in modern mode are zero.

The byte content of the map needs the bench's scenarios to show. These include the bit-to-ID placement, the zero padding above the processor count, persistence after repeated adds, and immunity to writes that are not a switch. The same holds for the reset values and for the priority of a hot-add over a clear in the same cycle.

// File: rtl/cpu_pres_pkg.sv
package cpu_pres_pkg;
    localparam int WIN_BYTES = 32;
    localparam int WIN_BITS  = WIN_BYTES * 8;
    localparam int ADDR_W    = $clog2(WIN_BYTES);
    localparam int ID_W      = $clog2(WIN_BITS);

    typedef enum logic {
        ST_LEGACY = 1'b0,
        ST_MODERN = 1'b1
    } mode_e;
endpackage

// File: rtl/cpu_pres_mode_fsm.sv
module cpu_pres_mode_fsm
    import cpu_pres_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] win_addr,
    input  logic [31:0]       wr_data,
    output logic              legacy_mode
);
    mode_e state_q, state_d;
    logic  switch_hit;

    // A zero store to any byte of word 0 retires the legacy view.
    assign switch_hit = wr_en && (win_addr < ADDR_W'(4)) && (wr_data == 32'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LEGACY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LEGACY: if (switch_hit) state_d = ST_MODERN; // SWITCH
            ST_MODERN: state_d = ST_MODERN;                 // STAY
            default:   state_d = ST_LEGACY;
        endcase
    end

    always_comb begin
        legacy_mode = 1'b0;
        unique case (state_q)
            ST_LEGACY: legacy_mode = 1'b1;
            ST_MODERN: legacy_mode = 1'b0;
            default:   legacy_mode = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpu_pres_map.sv
module cpu_pres_map
    import cpu_pres_pkg::*;
#(
    parameter int                 N_CPU        = 20,
    parameter logic [N_CPU-1:0]   INIT_PRESENT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ID_W-1:0]   set_id,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              view_en,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    logic [N_CPU-1:0]    present_q;
    logic [WIN_BITS-1:0] window;
    logic [7:0]          sel_byte;

    // One sticky flop per processor; nothing in this view clears a bit.
    for (genvar i = 0; i < N_CPU; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                present_q[i] <= INIT_PRESENT[i];
            else if (set_en && (set_id == ID_W'(i)))
                present_q[i] <= 1'b1;
        end
    end

    // Pad the map to the full window; unpopulated positions read zero.
    for (genvar j = 0; j < WIN_BITS; j++) begin : g_pad
        if (j < N_CPU) begin : g_live
            assign window[j] = present_q[j];
        end else begin : g_zero
            assign window[j] = 1'b0;
        end
    end

    assign sel_byte = window[{rd_addr, 3'b000} +: 8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= view_en ? sel_byte : 8'h00;
        end
    end
endmodule

// File: rtl/cpu_pres_gpe.sv
module cpu_pres_gpe (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic evt_en,
    output logic evt_sts,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n)       evt_sts <= 1'b0;
        else if (set_evt) evt_sts <= 1'b1;   // a new event beats a clear
        else if (clr_evt) evt_sts <= 1'b0;
    end

    assign irq = evt_sts & evt_en;
endmodule

// File: rtl/cpu_pres_legacy_port.sv
module cpu_pres_legacy_port
    import cpu_pres_pkg::*;
#(
    parameter int               N_CPU        = 20,
    parameter logic [N_CPU-1:0] INIT_PRESENT = N_CPU'(3)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hot_add_valid,
    input  logic [7:0]  hot_add_id,
    input  logic [4:0]  win_addr,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        gpe_en,
    input  logic        gpe_clr,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic        gpe_sts,
    output logic        sci,
    output logic        legacy_mode
);
    logic add_ok;

    assign add_ok = hot_add_valid && legacy_mode &&
                    ({1'b0, hot_add_id} < (ID_W + 1)'(N_CPU));

    cpu_pres_mode_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .win_addr   (win_addr),
        .wr_data    (wr_data),
        .legacy_mode(legacy_mode)
    );

    cpu_pres_map #(
        .N_CPU       (N_CPU),
        .INIT_PRESENT(INIT_PRESENT)
    ) i_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (add_ok),
        .set_id  (hot_add_id),
        .rd_en   (rd_en),
        .rd_addr (win_addr),
        .view_en (legacy_mode),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    cpu_pres_gpe i_gpe (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(add_ok),
        .clr_evt(gpe_clr),
        .evt_en (gpe_en),
        .evt_sts(gpe_sts),
        .irq    (sci)
    );
endmodule

// File: rtl/cpu_pres_legacy_checker.sv
module cpu_pres_legacy_checker #(
    parameter int N_CPU = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hot_add_valid,
    input logic [7:0]  hot_add_id,
    input logic [4:0]  win_addr,
    input logic        rd_en,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        gpe_en,
    input logic        gpe_clr,
    input logic [7:0]  rd_data,
    input logic        rd_valid,
    input logic        gpe_sts,
    input logic        sci,
    input logic        legacy_mode
);
    logic acc;
    assign acc = hot_add_valid && legacy_mode && ({1'b0, hot_add_id} < 9'(N_CPU));

    assert_rdvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_rdvalid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    assert_add_sets_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> gpe_sts);
    assert_status_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gpe_sts) |-> $past(acc));
    assert_switch_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(legacy_mode) |-> $past(wr_en && (win_addr < 5'd4) && (wr_data == 32'd0)));
    assert_modern_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_mode |=> !legacy_mode);
    assert_modern_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(legacy_mode)) |-> (rd_data == 8'h00));
    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_sts && !gpe_clr) |=> gpe_sts);
    assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_clr && !hot_add_valid) |=> !gpe_sts);
    assert_sci_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> (gpe_sts && gpe_en));
endmodule

bind cpu_pres_legacy_port cpu_pres_legacy_checker #(.N_CPU(N_CPU)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hot_add_valid(hot_add_valid),
    .hot_add_id   (hot_add_id),
    .win_addr     (win_addr),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .gpe_en       (gpe_en),
    .gpe_clr      (gpe_clr),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .gpe_sts      (gpe_sts),
    .sci          (sci),
    .legacy_mode  (legacy_mode)
);

// File: tb/test_cpu_pres_legacy_port.sv
module test_cpu_pres_legacy_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hot_add_valid = 1'b0;
    logic [7:0]  hot_add_id = '0;
    logic [4:0]  win_addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        gpe_en = 1'b0;
    logic        gpe_clr = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        gpe_sts;
    logic        sci;
    logic        legacy_mode;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    cpu_pres_legacy_port #(.N_CPU(20), .INIT_PRESENT(20'h00003)) i_cpu_pres_legacy_port (
        .clk(clk), .rst_n(rst_n), .hot_add_valid(hot_add_valid), .hot_add_id(hot_add_id),
        .win_addr(win_addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .gpe_en(gpe_en), .gpe_clr(gpe_clr), .rd_data(rd_data), .rd_valid(rd_valid),
        .gpe_sts(gpe_sts), .sci(sci), .legacy_mode(legacy_mode)
    );

    // kind: 0 none, 1 hot-add of id, 2 write data at addr; then a byte read.
    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  id;
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic [4:0]  raddr;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VEC [0:10] = '{
        '{2'd0, 8'd0,   5'd0, 32'd0, 5'd0,  8'h03, 4'd1}, // R1 power-up bits 0,1
        '{2'd0, 8'd0,   5'd0, 32'd0, 5'd1,  8'h00, 4'd2}, // R2 byte 1 empty
        '{2'd1, 8'd9,   5'd0, 32'd0, 5'd1,  8'h02, 4'd4}, // R4 id 9 -> byte1 bit1
        '{2'd1, 8'd19,  5'd0, 32'd0, 5'd2,  8'h08, 4'd4}, // R4 id 19 -> byte2 bit3
        '{2'd1, 8'd20,  5'd0, 32'd0, 5'd2,  8'h08, 4'd5}, // R5 id 20 out of range
        '{2'd1, 8'd200, 5'd0, 32'd0, 5'd25, 8'h00, 4'd3}, // R3 padding reads zero
        '{2'd2, 8'd0,   5'd0, 32'd5, 5'd0,  8'h03, 4'd6}, // R6 nonzero write word 0
        '{2'd2, 8'd0,   5'd8, 32'd0, 5'd0,  8'h03, 4'd6}, // R6 zero write other word
        '{2'd2, 8'd0,   5'd3, 32'd1, 5'd1,  8'h02, 4'd6}, // R6 nonzero write byte 3
        '{2'd1, 8'd0,   5'd0, 32'd0, 5'd0,  8'h03, 4'd6}, // R6 re-add keeps bits
        '{2'd0, 8'd0,   5'd0, 32'd0, 5'd31, 8'h00, 4'd3}  // R3 last byte zero
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge: drives for one cycle, returns at the next negedge.
    task automatic do_add(input logic [7:0] id);
        hot_add_valid = 1'b1; hot_add_id = id;
        @(negedge clk);
        hot_add_valid = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; win_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [7:0] got, output logic vld);
        rd_en = 1'b1; win_addr = a;
        @(negedge clk);
        got = rd_data; vld = rd_valid;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (500) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic       vld;
        repeat (3) @(negedge clk);
        check("R1 rd_data", 32'(rd_data), 0);
        check("R1 rd_valid", 32'(rd_valid), 0);
        check("R1 gpe_sts", 32'(gpe_sts), 0);
        check("R1 legacy_mode", 32'(legacy_mode), 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i <= 10; i++) begin
            if (VEC[i].kind == 2'd1) do_add(VEC[i].id);
            else if (VEC[i].kind == 2'd2) do_write(VEC[i].waddr, VEC[i].wdata);
            do_read(VEC[i].raddr, got, vld);
            check($sformatf("R%0d vec%0d rd_data", VEC[i].req, i), 32'(got), 32'(VEC[i].exp));
            check($sformatf("R2 vec%0d rd_valid", i), 32'(vld), 1);
        end
        check("R6 still legacy", 32'(legacy_mode), 1);
        check("R2 rd_valid drops", 32'(rd_valid), 1);
        @(negedge clk);
        check("R2 rd_valid idle", 32'(rd_valid), 0);

        // Event status and interrupt gating
        check("R4 status latched", 32'(gpe_sts), 1);
        gpe_en = 1'b0; #1;
        check("R9 sci masked", 32'(sci), 0);
        gpe_en = 1'b1; #1;
        check("R9 sci enabled", 32'(sci), 1);
        gpe_clr = 1'b1; @(negedge clk); gpe_clr = 1'b0;
        check("R9 clear", 32'(gpe_sts), 0);
        check("R9 sci after clear", 32'(sci), 0);
        do_add(8'd25);
        check("R5 no status", 32'(gpe_sts), 0);
        gpe_clr = 1'b1; do_add(8'd5); gpe_clr = 1'b0;
        check("R9 add beats clear", 32'(gpe_sts), 1);
        do_read(5'd0, got, vld);
        check("R4 id 5 set", 32'(got), 32'h23);
        gpe_clr = 1'b1; @(negedge clk); gpe_clr = 1'b0;

        // Mode switch
        do_write(5'd2, 32'd0);
        check("R7 switched", 32'(legacy_mode), 0);
        do_read(5'd0, got, vld);
        check("R8 read zero", 32'(got), 0);
        do_add(8'd7);
        check("R8 add ignored", 32'(gpe_sts), 0);
        do_write(5'd0, 32'h1);
        check("R8 stays modern", 32'(legacy_mode), 0);

        // Reset restores power-up state
        rst_n = 1'b0; repeat (2) @(negedge clk);
        check("R1 reset mode", 32'(legacy_mode), 1);
        check("R1 reset status", 32'(gpe_sts), 0);
        rst_n = 1'b1; @(negedge clk);
        do_read(5'd1, got, vld);
        check("R1 byte1 cleared", 32'(got), 0);
        do_read(5'd0, got, vld);
        check("R1 byte0 init", 32'(got), 32'h03);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule